// File: doc/BRIEF.md
# Quantized-Index Function Table Unit

This block evaluates two-operand arithmetic without any datapath arithmetic. Every variable is carried as the index of a codeword in that variable's codebook. Each of a set of small on-chip tables holds one precomputed function of two such indices, for example a squared difference or a log-domain sum. A lookup joins the two operand indices into a table address. The stored word is the index of the codeword nearest to the function's result.

Several request ports can each issue one lookup per cycle to any table. Lookups to different tables proceed in parallel. When two ports name the same table in one cycle, only one of them is served. A returned result index has the same form as an operand index, so a chain of functions is evaluated as a sequence of dependent lookups. A host write port fills the tables before use.

Top module: `cil_lookup_unit`

## Requirements
- R1: A lookup on table T with operand indices A (OPA_W bits) and B (OPB_W bits) returns the RES_W-bit word stored in table T at address {A, B}, with A in the upper bits and B in the lower bits.
- R2: An accepted request (req_valid and req_ready both high on a port at a clock edge) raises res_valid on that port at the next edge, together with the result index. A port with no accepted request shows res_valid low one cycle later.
- R3: With each result, res_tbl on the port repeats the table number of the request that produced it.
- R4: Requests from different ports to different tables in the same cycle are all accepted, and all of them return results in the following cycle.
- R5: When several ports request the same table in one cycle, the lowest-numbered port among them is accepted. The others see req_ready low, get no result, and may retry in a later cycle. Port 0 is never refused.
- R6: While rst is high and in the cycle after it, res_valid is low on all ports. After reset, every table entry reads as zero until it is written.
- R7: A host write (wr_en, wr_tbl, wr_addr, wr_data) updates one entry at the clock edge. A lookup of the same entry in that same cycle returns the previous contents, and later lookups return the new word.
- R8: A result index fed back unchanged as an operand index of a later lookup gives the composed function value.
- R9: A host write changes only the addressed entry of the selected table. The same address in any other table is unaffected.
- R10: In a table where only some entries have been written since reset, the entries that have not been written still read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_PORTS | Lookup request per port |
| req_tbl | input | NUM_PORTS*SEL_W | Table number per port |
| req_opa | input | NUM_PORTS*OPA_W | First operand index per port (upper address bits) |
| req_opb | input | NUM_PORTS*OPB_W | Second operand index per port (lower address bits) |
| req_ready | output | NUM_PORTS | Request accepted this cycle (high when the port is idle) |
| res_valid | output | NUM_PORTS | Result present, one cycle after acceptance |
| res_tbl | output | NUM_PORTS*SEL_W | Table number that produced the result |
| res_idx | output | NUM_PORTS*RES_W | Result codeword index |
| wr_en | input | 1 | Host table write strobe |
| wr_tbl | input | SEL_W | Host write table number |
| wr_addr | input | OPA_W+OPB_W | Host write address {A, B} |
| wr_data | input | RES_W | Host write word |

## Verification
A corrupted table entry or a swapped address half shows up as a wrong res_idx one cycle after the affected lookup. Because of this, the bench loads every table with a computed function and sweeps all operand pairs of every table. An arbitration fault shows in the same cycle on req_ready, and one cycle later as a missing, duplicated or misrouted res_valid/res_tbl. A wrong read-during-write order, or a leak between tables, appears on the first lookup after the write. A lost reset of the written-entry marks appears as non-zero data from a table that has not been loaded.

// File: rtl/cil_pkg.sv
package cil_pkg;
  function automatic int sel_width(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/cil_arb.sv
// Fixed-priority arbiter: the lowest set request bit wins.
module cil_arb #(
  parameter int N = 4,
  localparam int IW = cil_pkg::sel_width(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt = '0;
        gnt[i] = 1'b1;
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cil_table.sv
// One function table: a read-first RAM with a registered read port and
// per-entry written marks, so that entries never written read as zero.
module cil_table #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  written;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written <= '0;
    end else if (wr_en) begin
      written[wr_addr] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= written[rd_addr] ? mem[rd_addr] : '0;
    end
  end
endmodule

// File: rtl/cil_lookup_unit.sv
module cil_lookup_unit #(
  parameter int NUM_TABLES = 8,
  parameter int NUM_PORTS  = 4,
  parameter int OPA_W      = 4,
  parameter int OPB_W      = 4,
  parameter int RES_W      = 4,
  localparam int SEL_W  = cil_pkg::sel_width(NUM_TABLES),
  localparam int PIDX_W = cil_pkg::sel_width(NUM_PORTS),
  localparam int ADDR_W = OPA_W + OPB_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_PORTS-1:0]         req_valid,
  input  logic [NUM_PORTS*SEL_W-1:0]   req_tbl,
  input  logic [NUM_PORTS*OPA_W-1:0]   req_opa,
  input  logic [NUM_PORTS*OPB_W-1:0]   req_opb,
  output logic [NUM_PORTS-1:0]         req_ready,
  output logic [NUM_PORTS-1:0]         res_valid,
  output logic [NUM_PORTS*SEL_W-1:0]   res_tbl,
  output logic [NUM_PORTS*RES_W-1:0]   res_idx,
  input  logic                         wr_en,
  input  logic [SEL_W-1:0]             wr_tbl,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [RES_W-1:0]             wr_data
);
  logic [SEL_W-1:0]     p_tbl  [NUM_PORTS];
  logic [ADDR_W-1:0]    p_addr [NUM_PORTS];
  logic [NUM_PORTS-1:0] t_hit  [NUM_TABLES];
  logic [NUM_PORTS-1:0] t_gnt  [NUM_TABLES];
  logic [NUM_TABLES-1:0] t_any;
  logic [PIDX_W-1:0]    t_idx  [NUM_TABLES];
  logic [RES_W-1:0]     t_rd   [NUM_TABLES];
  logic [NUM_PORTS-1:0] granted;
  logic [NUM_PORTS-1:0] valid_q;
  logic [SEL_W-1:0]     tbl_q  [NUM_PORTS];

  // Per-port request fields; the address is {A, B}.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_in
    assign p_tbl[p]  = req_tbl[p*SEL_W +: SEL_W];
    assign p_addr[p] = {req_opa[p*OPA_W +: OPA_W], req_opb[p*OPB_W +: OPB_W]};
  end

  // One arbiter and one table per function.
  for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hit
      assign t_hit[t][p] = req_valid[p] && (p_tbl[p] == SEL_W'(t));
    end

    cil_arb #(.N(NUM_PORTS)) u_arb (
      .req (t_hit[t]),
      .gnt (t_gnt[t]),
      .any (t_any[t]),
      .idx (t_idx[t])
    );

    cil_table #(.ADDR_W(ADDR_W), .DATA_W(RES_W)) u_table (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en && (wr_tbl == SEL_W'(t))),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_en   (t_any[t]),
      .rd_addr (p_addr[t_idx[t]]),
      .rd_data (t_rd[t])
    );
  end

  always_comb begin
    granted = '0;
    for (int t = 0; t < NUM_TABLES; t++) granted = granted | t_gnt[t];
  end

  assign req_ready = ~req_valid | granted;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      for (int p = 0; p < NUM_PORTS; p++) tbl_q[p] <= '0;
    end else begin
      valid_q <= req_valid & granted;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (req_valid[p] && granted[p]) tbl_q[p] <= p_tbl[p];
      end
    end
  end

  // Route each table's registered read word back to the port it served.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_out
    assign res_valid[p]               = valid_q[p];
    assign res_tbl[p*SEL_W +: SEL_W]  = tbl_q[p];
    assign res_idx[p*RES_W +: RES_W]  =
      (int'(tbl_q[p]) < NUM_TABLES) ? t_rd[tbl_q[p]] : '0;
  end
endmodule

// File: rtl/cil_lookup_unit_chk.sv
module cil_lookup_unit_chk #(
  parameter int NUM_TABLES = 8,
  parameter int NUM_PORTS  = 4,
  parameter int OPA_W      = 4,
  parameter int OPB_W      = 4,
  parameter int RES_W      = 4,
  localparam int SEL_W  = cil_pkg::sel_width(NUM_TABLES),
  localparam int ADDR_W = OPA_W + OPB_W
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_PORTS-1:0]       req_valid,
  input logic [NUM_PORTS*SEL_W-1:0] req_tbl,
  input logic [NUM_PORTS*OPA_W-1:0] req_opa,
  input logic [NUM_PORTS*OPB_W-1:0] req_opb,
  input logic [NUM_PORTS-1:0]       req_ready,
  input logic [NUM_PORTS-1:0]       res_valid,
  input logic [NUM_PORTS*SEL_W-1:0] res_tbl,
  input logic [NUM_PORTS*RES_W-1:0] res_idx,
  input logic                       wr_en,
  input logic [SEL_W-1:0]           wr_tbl,
  input logic [ADDR_W-1:0]          wr_addr,
  input logic [RES_W-1:0]           wr_data
);
  logic [NUM_PORTS-1:0] acc;
  assign acc = req_valid & req_ready;

  // R6: no result during reset or in the cycle after it.
  a_r6_reset_quiet: assert property (@(posedge clk) rst |=> (res_valid == '0));

  // R5: port 0 has top priority and is never refused.
  a_r5_port0_served: assert property (@(posedge clk) disable iff (rst)
    req_valid[0] |-> req_ready[0]);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
    // R2: acceptance gives a result one cycle later.
    a_r2_result_follows: assert property (@(posedge clk) disable iff (rst)
      acc[p] |=> res_valid[p]);
    // R2: no acceptance gives no result.
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
      !acc[p] |=> !res_valid[p]);
    // R3: table number is echoed.
    a_r3_tbl_echo: assert property (@(posedge clk) disable iff (rst)
      acc[p] |=> (res_tbl[p*SEL_W +: SEL_W] == $past(req_tbl[p*SEL_W +: SEL_W])));
  end

  for (genvar t = 0; t < NUM_TABLES; t++) begin : g_t
    logic [NUM_PORTS-1:0] acc_t;
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_m
      assign acc_t[p] = acc[p] && (req_tbl[p*SEL_W +: SEL_W] == SEL_W'(t));
    end
    // R5: each table accepts at most one request per cycle.
    a_r5_one_per_table: assert property (@(posedge clk) disable iff (rst)
      $onehot0(acc_t));
  end
endmodule

bind cil_lookup_unit cil_lookup_unit_chk #(
  .NUM_TABLES (NUM_TABLES),
  .NUM_PORTS  (NUM_PORTS),
  .OPA_W      (OPA_W),
  .OPB_W      (OPB_W),
  .RES_W      (RES_W)
) u_chk (.*);

// File: tb/test_cil_lookup_unit.sv
module test_cil_lookup_unit;
  localparam int NT = 8, NP = 4, AW = 4, BW = 4, RW = 4, SW = 3;

  logic clk = 1'b0;
  logic rst;
  logic [NP-1:0]    req_valid;
  logic [NP*SW-1:0] req_tbl;
  logic [NP*AW-1:0] req_opa;
  logic [NP*BW-1:0] req_opb;
  logic [NP-1:0]    req_ready, res_valid;
  logic [NP*SW-1:0] res_tbl;
  logic [NP*RW-1:0] res_idx;
  logic             wr_en;
  logic [SW-1:0]    wr_tbl;
  logic [AW+BW-1:0] wr_addr;
  logic [RW-1:0]    wr_data;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  cil_lookup_unit #(.NUM_TABLES(NT), .NUM_PORTS(NP), .OPA_W(AW), .OPB_W(BW), .RES_W(RW))
    i_cil_lookup_unit (.*);

  function automatic int fval(int t, int a, int b);
    return (a * (t + 1) + b * b + t) & 15;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_req(int p, int t, int a, int b);
    req_valid[p] = 1'b1;
    req_tbl[p*SW +: SW] = SW'(t);
    req_opa[p*AW +: AW] = AW'(a);
    req_opb[p*BW +: BW] = BW'(b);
  endtask

  function automatic int got(int p);
    return int'(res_idx[p*RW +: RW]);
  endfunction

  task automatic lookup(string tag, int p, int t, int a, int b, int exp);
    @(negedge clk);
    set_req(p, t, a, b);
    #1 chk({tag, " ready"}, req_ready[p], 1);
    @(negedge clk);
    chk({tag, " valid"}, res_valid[p], 1);
    chk({tag, " tbl"}, res_tbl[p*SW +: SW], t);
    chk({tag, " idx"}, got(p), exp);
    req_valid[p] = 1'b0;
  endtask

  initial begin
    int r;
    rst = 1'b1; req_valid = '0; req_tbl = '0; req_opa = '0; req_opb = '0;
    wr_en = 1'b0; wr_tbl = '0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R6 valid in reset", res_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R6 valid after reset", res_valid, 0);

    // R6: unloaded tables read zero
    for (int t = 0; t < NT; t++) lookup("R6 zero read", t % NP, t, t, 15 - t, 0);

    // R10: a single written entry; its neighbour stays zero
    @(negedge clk);
    wr_en = 1'b1; wr_tbl = 3'd7; wr_addr = 8'h05; wr_data = 4'd9;
    @(negedge clk);
    wr_en = 1'b0;
    lookup("R10 written", 1, 7, 0, 5, 9);
    lookup("R10 unwritten", 2, 7, 0, 6, 0);

    // load all tables
    for (int t = 0; t < NT; t++)
      for (int ad = 0; ad < 256; ad++) begin
        @(negedge clk);
        wr_en = 1'b1; wr_tbl = SW'(t); wr_addr = 8'(ad);
        wr_data = RW'(fval(t, ad >> 4, ad & 15));
      end
    @(negedge clk);
    wr_en = 1'b0;

    // R1: exhaustive sweep, port rotates
    for (int t = 0; t < NT; t++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          lookup("R1 sweep", (a + b) % NP, t, a, b, fval(t, a, b));

    // R4: all ports, distinct tables, same cycle
    @(negedge clk);
    for (int p = 0; p < NP; p++) set_req(p, 2 * p + 1, p + 4, 3 * p);
    #1 chk("R4 all ready", req_ready, 4'hF);
    @(negedge clk);
    chk("R4 all valid", res_valid, 4'hF);
    for (int p = 0; p < NP; p++) chk("R4 idx", got(p), fval(2 * p + 1, p + 4, 3 * p));
    req_valid = '0;

    // R5: ports 1..3 contend for table 5
    @(negedge clk);
    set_req(1, 5, 1, 2); set_req(2, 5, 3, 4); set_req(3, 5, 5, 6);
    #1 chk("R5 ready pattern", req_ready, 4'b0011);
    @(negedge clk);
    chk("R5 winner valid", res_valid, 4'b0010);
    chk("R5 winner idx", got(1), fval(5, 1, 2));
    req_valid[1] = 1'b0;
    #1 chk("R5 retry ready", req_ready, 4'b0111);
    @(negedge clk);
    chk("R5 retry valid", res_valid, 4'b0100);
    chk("R5 retry idx", got(2), fval(5, 3, 4));
    req_valid[2] = 1'b0;
    #1 chk("R5 last ready", req_ready[3], 1);
    @(negedge clk);
    chk("R5 last valid", res_valid, 4'b1000);
    chk("R5 last idx", got(3), fval(5, 5, 6));
    req_valid[3] = 1'b0;

    // R7: read during write returns old, then new
    @(negedge clk);
    wr_en = 1'b1; wr_tbl = 3'd2; wr_addr = 8'h34; wr_data = RW'(fval(2, 3, 4) + 7);
    set_req(0, 2, 3, 4);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R7 old contents", got(0), fval(2, 3, 4));
    @(negedge clk);
    chk("R7 new contents", got(0), (fval(2, 3, 4) + 7) & 15);
    req_valid[0] = 1'b0;
    // R9: same address of another table untouched
    lookup("R9 other table", 1, 3, 3, 4, fval(3, 3, 4));

    // R8: chain a result into the next lookup
    @(negedge clk);
    set_req(0, 0, 6, 9);
    @(negedge clk);
    r = got(0);
    chk("R8 first stage", r, fval(0, 6, 9));
    req_valid[0] = 1'b0;
    set_req(1, 1, r, 2);
    @(negedge clk);
    chk("R8 chained", got(1), fval(1, fval(0, 6, 9), 2));
    req_valid[1] = 1'b0;
    @(negedge clk);
    chk("R2 idle no valid", res_valid, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R2 actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule